// File: doc/BRIEF.md
# Two-Channel Audio Frame Sync Generator

This block produces the bit timing and the frame marker for a two-channel serial audio link. It keeps a bit-position counter inside the current frame, and a channel serializer next to it reads that counter to decide when each sample bit goes out or comes in. The frame length and the length of the sync pulse are both programmable, in bit clocks. The system-clock divider sits outside the block. It supplies a half-bit enable pulse, `bitClkEn`.

The bit clock and the frame sync each have their own direction select. The block can drive both, drive one and receive the other, or receive both. Each signal also has its own polarity control. The polarity sense is reversed from the usual audio convention: the internal reference phase is the opposite of the standard serial audio format, so standard polarity needs both inversion controls set. External clock and sync inputs pass through two-flop synchronizers before use. In sync-receive mode the counter aligns itself to the active edge of the incoming frame sync.

Top module: `audio_frame_sync`

## Requirements
- R1: While `rstN` is low, `bitPos` is 0 and `bitTick` is 0. The internal bit-clock phase starts at 0.
- R2: With `bclkSlave`=0, each cycle with `bitClkEn`=1 toggles the internal phase. `bitPos` advances by one on an enabled cycle where the phase was 1, so it advances once per two enables.
- R3: After `bitPos` equals `frameLenM1`, the next bit step sets it to 0. With `frameLenM1`=0 it stays at 0.
- R4: The internal frame-sync level is active exactly while `bitPos` < `syncLen`. `syncLen`=0 never asserts it, and a value above `frameLenM1` asserts it for the whole frame.
- R5: When the block drives the bit clock, `bclkOut` equals the phase if `bclkInv`=1 and its complement if `bclkInv`=0. With `bclkInv`=1, bits advance on the falling edge of the pin.
- R6: When the block drives frame sync (`fsSlave`=0), `fsOe`=1 and `fsOut` = active level XOR `fsInv`. So `fsInv`=1 gives an active-low sync.
- R7: `clkOutDis`=1 forces `bclkOe`=0 and `bclkOut`=0. Bit counting is unchanged.
- R8: With `bclkSlave`=1, `bclkOe`=0 and `bitClkEn` is ignored. The normalized input is `bclkIn` if `bclkInv`=1, otherwise its complement. Each falling edge of the normalized input advances `bitPos` exactly once, and the count is settled 3 clocks after the pin changes.
- R9: With `fsSlave`=1, `fsOe`=0 and `fsOut`=0. On a bit step where the normalized sync (`fsIn` XOR `fsInv`) is 1 and was 0 at the previous bit step, `bitPos` becomes 0 instead of advancing.
- R10: The two direction selects are independent. With the bit clock received and frame sync driven, `fsOut` still follows R4 and R6 from the received bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitClkEn | input | 1 | Half-bit enable from the clock divider |
| frameLenM1 | input | 10 | Frame length in bit clocks minus one |
| syncLen | input | 10 | Bit clocks for which frame sync stays active |
| bclkSlave | input | 1 | 1: bit clock is received on `bclkIn` |
| fsSlave | input | 1 | 1: frame sync is received on `fsIn` |
| bclkInv | input | 1 | Bit clock polarity control |
| fsInv | input | 1 | Frame sync polarity control |
| clkOutDis | input | 1 | Disable the driven bit clock pin |
| bclkIn | input | 1 | External bit clock |
| fsIn | input | 1 | External frame sync |
| bclkOut | output | 1 | Driven bit clock level |
| bclkOe | output | 1 | Bit clock output enable |
| fsOut | output | 1 | Driven frame sync level |
| fsOe | output | 1 | Frame sync output enable |
| bitPos | output | 10 | Bit position within the frame |
| bitTick | output | 1 | One-cycle strobe on each bit step |

## Verification
In master mode the bench drives an irregular enable pattern over frame lengths from 1 to 8 bits. Sync lengths of zero, mid-frame and longer-than-frame cover the full range of the compare, and every polarity pairing is tried. This separates the half-bit phase from the bit step and exercises the wrap point. In slave mode the bench toggles the clock pin slowly while `bitClkEn` stays high. One slave case feeds a sync whose period is shorter than the programmed frame, so only the realignment can explain the observed count. Another keeps the sync driven, which checks the direction selects independently of each other.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  typedef struct packed {
    logic bitTick;  // one bit step this cycle
    logic resync;   // force the bit counter to zero on this step
  } fsStrobe_t;
endpackage

// File: rtl/fsync_ctrl.sv
module fsync_ctrl
  import fsync_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitClkEn,
  input  logic      bclkSlave,
  input  logic      fsSlave,
  input  logic      bclkInv,
  input  logic      fsInv,
  input  logic      bclkIn,
  input  logic      fsIn,
  output logic      phase,
  output fsStrobe_t strobe
);
  localparam int Last = SyncStages - 1;

  logic [Last:0] bclkSync;
  logic [Last:0] fsSync;
  logic bclkNorm, bclkNormQ, fsNorm, fsPrev;
  logic masterTick, slaveTick, tick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkSync <= '0;
      fsSync   <= '0;
    end else begin
      bclkSync <= {bclkSync[Last-1:0], bclkIn};
      fsSync   <= {fsSync[Last-1:0], fsIn};
    end
  end

  assign bclkNorm = bclkInv ? bclkSync[Last] : ~bclkSync[Last];
  assign fsNorm   = fsSync[Last] ^ fsInv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= 1'b0;
      bclkNormQ <= 1'b0;
      fsPrev    <= 1'b0;
    end else begin
      if (bitClkEn) phase <= ~phase;
      bclkNormQ <= bclkNorm;
      if (tick) fsPrev <= fsNorm;
    end
  end

  assign masterTick = bitClkEn & phase;
  assign slaveTick  = bclkNormQ & ~bclkNorm;
  assign tick       = bclkSlave ? slaveTick : masterTick;

  assign strobe.bitTick = tick;
  assign strobe.resync  = fsSlave & tick & fsNorm & ~fsPrev;

  p_slave_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bclkSlave && tick) |-> ($past(bclkNorm) && !bclkNorm));
  p_master_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!bclkSlave && tick) |=> (phase == 1'b0));
  p_resync_edge_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.resync |=> fsPrev);
endmodule

// File: rtl/fsync_dp.sv
module fsync_dp
  import fsync_pkg::*;
#(
  parameter int LenW = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  fsStrobe_t       strobe,
  input  logic [LenW-1:0] frameLenM1,
  input  logic [LenW-1:0] syncLen,
  output logic [LenW-1:0] bitPos,
  output logic            fsActive
);
  localparam logic [LenW-1:0] One = LenW'(1);

  logic atEnd;
  assign atEnd = (bitPos == frameLenM1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitPos <= '0;
    end else if (strobe.bitTick) begin
      if (strobe.resync || atEnd) bitPos <= '0;
      else                        bitPos <= bitPos + One;
    end
  end

  assign fsActive = (bitPos < syncLen);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bitTick && atEnd) |=> (bitPos == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bitTick && !strobe.resync && !atEnd) |=> (bitPos == $past(bitPos) + One));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.bitTick |=> $stable(bitPos));
  p_resync_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.resync |=> (bitPos == '0));
endmodule

// File: rtl/audio_frame_sync.sv
module audio_frame_sync
  import fsync_pkg::*;
#(
  parameter int LenW       = 10,
  parameter int SyncStages = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            bitClkEn,
  input  logic [LenW-1:0] frameLenM1,
  input  logic [LenW-1:0] syncLen,
  input  logic            bclkSlave,
  input  logic            fsSlave,
  input  logic            bclkInv,
  input  logic            fsInv,
  input  logic            clkOutDis,
  input  logic            bclkIn,
  input  logic            fsIn,
  output logic            bclkOut,
  output logic            bclkOe,
  output logic            fsOut,
  output logic            fsOe,
  output logic [LenW-1:0] bitPos,
  output logic            bitTick
);
  fsStrobe_t strobe;
  logic phase, fsActive;

  fsync_ctrl #(.SyncStages(SyncStages)) uCtrl (
    .clk(clk), .rstN(rstN), .bitClkEn(bitClkEn),
    .bclkSlave(bclkSlave), .fsSlave(fsSlave),
    .bclkInv(bclkInv), .fsInv(fsInv),
    .bclkIn(bclkIn), .fsIn(fsIn),
    .phase(phase), .strobe(strobe)
  );

  fsync_dp #(.LenW(LenW)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .frameLenM1(frameLenM1), .syncLen(syncLen),
    .bitPos(bitPos), .fsActive(fsActive)
  );

  assign bclkOe  = ~bclkSlave & ~clkOutDis;
  assign bclkOut = bclkOe & (bclkInv ? phase : ~phase);
  assign fsOe    = ~fsSlave;
  assign fsOut   = fsOe & (fsActive ^ fsInv);
  assign bitTick = strobe.bitTick;

  p_reset_r1: assert property (@(posedge clk) !rstN |=> (bitPos == '0));
endmodule

// File: tb/sim_audio_frame_sync.sv
module sim_audio_frame_sync;
  localparam int PERIOD = 10;
  localparam int LenW   = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitClkEn = 1'b0;
  logic [LenW-1:0] frameLenM1 = '0, syncLen = '0;
  logic bclkSlave = 1'b0, fsSlave = 1'b0, bclkInv = 1'b0, fsInv = 1'b0, clkOutDis = 1'b0;
  logic bclkIn = 1'b0, fsIn = 1'b0;
  logic bclkOut, bclkOe, fsOut, fsOe, bitTick;
  logic [LenW-1:0] bitPos;

  int checks = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  audio_frame_sync #(.LenW(LenW)) u0 (
    .clk(clk), .rstN(rstN), .bitClkEn(bitClkEn),
    .frameLenM1(frameLenM1), .syncLen(syncLen),
    .bclkSlave(bclkSlave), .fsSlave(fsSlave),
    .bclkInv(bclkInv), .fsInv(fsInv), .clkOutDis(clkOutDis),
    .bclkIn(bclkIn), .fsIn(fsIn),
    .bclkOut(bclkOut), .bclkOe(bclkOe), .fsOut(fsOut), .fsOe(fsOe),
    .bitPos(bitPos), .bitTick(bitTick)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    bitClkEn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 bitPos in reset", int'(bitPos), 0);
    chk("R1 bitTick in reset", int'(bitTick), 0);
    rstN = 1'b1;
  endtask

  // master-driven bit clock and frame sync
  task automatic runMaster(input int m1, input int sl, input bit bi, input bit fi,
                           input bit dis, input int n);
    int ph = 0;
    int pos = 0;
    frameLenM1 = LenW'(m1); syncLen = LenW'(sl);
    bclkSlave = 1'b0; fsSlave = 1'b0; bclkInv = bi; fsInv = fi; clkOutDis = dis;
    doReset();
    for (int c = 0; c < n; c++) begin
      chk("R2 R3 bitPos master", int'(bitPos), pos);
      chk("R5 R7 bclkOut", int'(bclkOut), dis ? 0 : (bi ? ph : 1 - ph));
      chk("R7 bclkOe", int'(bclkOe), dis ? 0 : 1);
      chk("R6 fsOe", int'(fsOe), 1);
      chk("R4 R6 fsOut", int'(fsOut), int'((pos < sl) ^ fi));
      bitClkEn = ((c * 7 + 3) % 5) != 0;
      @(posedge clk);
      if (bitClkEn) begin
        if (ph == 1) pos = (pos == m1) ? 0 : pos + 1;
        ph = 1 - ph;
      end
      @(negedge clk);
    end
    bitClkEn = 1'b0;
  endtask

  // received bit clock; frame sync received or driven
  task automatic runSlave(input int m1, input int sl, input bit bi, input bit fi,
                          input bit fsl, input int per, input int edges);
    int pos = 0;
    bit prevFs = 0;
    frameLenM1 = LenW'(m1); syncLen = LenW'(sl);
    bclkSlave = 1'b1; fsSlave = fsl; bclkInv = bi; fsInv = fi; clkOutDis = 1'b0;
    bclkIn = bi ? 1'b1 : 1'b0;   // normalized level 1
    fsIn = fi;                   // normalized level 0
    doReset();
    bitClkEn = 1'b1;             // must be ignored (R8)
    repeat (4) @(negedge clk);
    chk("R8 bitPos idle", int'(bitPos), 0);
    for (int j = 0; j < edges; j++) begin
      bit fsN;
      fsN = (j % per) < 2;
      bclkIn = bi ? 1'b0 : 1'b1;  // normalized falling edge
      fsIn = fsN ^ fi;
      if (fsl && fsN && !prevFs) pos = 0;
      else pos = (pos == m1) ? 0 : pos + 1;
      prevFs = fsN;
      repeat (4) @(negedge clk);
      chk(fsl ? "R8 R9 bitPos slave" : "R8 bitPos slave", int'(bitPos), pos);
      chk("R8 bclkOe", int'(bclkOe), 0);
      chk("R9 R10 fsOe", int'(fsOe), fsl ? 0 : 1);
      chk("R9 R10 fsOut", int'(fsOut), fsl ? 0 : int'((pos < sl) ^ fi));
      bclkIn = bi ? 1'b1 : 1'b0;  // normalized rising edge, no step
      repeat (4) @(negedge clk);
      chk("R8 bitPos after rise", int'(bitPos), pos);
    end
    bitClkEn = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    runMaster(3, 2, 1, 1, 0, 80);   // standard polarity
    runMaster(7, 4, 0, 0, 0, 120);  // reversed polarity
    runMaster(5, 0, 1, 0, 0, 90);   // R4 never active
    runMaster(4, 9, 0, 1, 0, 90);   // R4 always active
    runMaster(0, 1, 1, 1, 0, 40);   // R3 single-bit frame
    runMaster(7, 3, 1, 1, 1, 100);  // R7 clock pin disabled
    runSlave(7, 4, 1, 1, 1, 6, 30); // R9 resync, period shorter than frame
    runSlave(7, 4, 0, 0, 0, 6, 30); // R10 clock in, sync out
    runSlave(5, 3, 0, 1, 1, 6, 24); // R9 matched period
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule